// File: doc/BRIEF.md
# Mixed-Endian Load/Store Data Path

This block sits between a processor's register bank and a little-endian memory data bus. It takes the low address bits and the size of a data access, and from them steers the addressed bytes between register and bus lanes. For loads it returns a register value that is always little-endian, zero- or sign-extended to 32 bits. For stores it returns the bus write data and the byte enables. A data-endianness state bit, together with two configuration inputs, selects one of three data modes: plain little-endian, byte-invariant big-endian, or legacy word-invariant big-endian. In byte-invariant big-endian mode, halfword and word values are byte-reversed on the way in and out, but they touch the same memory bytes as in little-endian mode.

The endianness state bit is a register. Software writes it through a control input. On reset, and on every exception entry, it reloads from a separate exception-endianness input. An instruction-fetch path beside the data path extracts 16- or 32-bit instructions as little-endian in every mode except legacy big-endian. It also flags a fetch that is not aligned to the instruction size. Accesses that would cross a bus word are not performed: the block raises a split request instead. The data and fetch paths are combinational; only the state bit is clocked.

Top module: `mxe_ldst_path`

## Requirements
- R1: The data mode decodes from the unaligned-enable input U, the legacy-big-endian input B and the state bit E as follows. (U,B,E)=(1,0,0) gives little-endian. (1,0,1) gives byte-invariant big-endian. (1,1,0) gives legacy big-endian. If U=0, or if (U,B,E)=(1,1,1), `cfg_err` is 1 and all accesses behave as little-endian; otherwise `cfg_err` is 0.
- R2: `e_bit` loads `exc_endian` on any clock edge where `rst_n` is low or `exc_entry` is high, even if a software write is requested in the same cycle. Otherwise, when `e_wr_en` is high, it loads `e_wr_val` on the next edge. Otherwise it holds its value.
- R3: `acc_size` encodes 0 for byte, 1 for halfword, and 2 or 3 for word. A byte access uses bus lane `acc_lsb` (lane n = bits 8n+7..8n). In legacy mode it uses lane `acc_lsb` XOR 3 instead. The byte is never reordered.
- R4: In byte-invariant big-endian mode, a halfword uses the same two lanes as in little-endian mode. The byte from the lower lane becomes the upper byte of the register value, for both loads and stores.
- R5: In byte-invariant big-endian mode, a word access reverses all four bytes: lane 0 maps to register bits 31..24, and so on.
- R6: In legacy mode, a halfword uses the lanes starting at `acc_lsb` XOR 2, with no byte swap. A word passes through unchanged.
- R7: When `acc_sign` is 1, a byte or halfword load result is sign-extended from its top bit after any reversal. When `acc_sign` is 0, it is zero-extended.
- R8: `mem_be` marks the lanes the access touches (lane n on bit n). The store data sits in those lanes, and all other `mem_wdata` bytes are 0. A halfword at offset 3 or a word at a non-zero offset crosses the bus word. So does any access in legacy mode that is not naturally aligned. For such an access, `split_req` is 1 and `mem_be`, `mem_wdata` and `ld_data` are all 0.
- R9: A 32-bit fetch (`if_half`=0) returns `if_rdata` unchanged. A 16-bit fetch returns the halfword in the lanes starting at `if_lsb`, or at `if_lsb` XOR 2 in legacy mode. The result is zero-extended, and E plays no part.
- R10: `if_fault` is 1 for a 16-bit fetch with `if_lsb[0]`=1, and for a 32-bit fetch with `if_lsb`≠0. While it is 1, `if_insn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_u | input | 1 | Unaligned/mixed-endian enable (U) |
| cfg_b | input | 1 | Legacy word-invariant big-endian select (B) |
| exc_endian | input | 1 | Exception-endianness value loaded into E |
| exc_entry | input | 1 | Exception entry strobe |
| e_wr_en | input | 1 | Software write of E |
| e_wr_val | input | 1 | Value for the software write |
| e_bit | output | 1 | Current data-endianness state bit E |
| cfg_err | output | 1 | Unsupported or reserved configuration |
| acc_lsb | input | 2 | Low address bits of the data access |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| acc_sign | input | 1 | Sign-extend byte/halfword loads |
| mem_rdata | input | 32 | Bus read data |
| st_data | input | 32 | Register value to store |
| ld_data | output | 32 | Register value loaded |
| mem_wdata | output | 32 | Bus write data |
| mem_be | output | 4 | Bus byte enables |
| split_req | output | 1 | Access crosses a bus word and is not performed |
| if_lsb | input | 2 | Low address bits of the fetch |
| if_half | input | 1 | 16-bit fetch when 1, 32-bit otherwise |
| if_rdata | input | 32 | Bus fetch data |
| if_insn | output | 32 | Extracted instruction |
| if_fault | output | 1 | Fetch alignment fault |

## Verification
The bench walks every size, offset and sign setting through each of the five configuration classes and compares every output against a byte-level model on every clock. A design that swapped byte order in the wrong mode would show reversed halfwords or words in little-endian or legacy mode. A design that extended before reversing would produce the wrong sign fill for big-endian halfwords. Missing the legacy lane XOR would read the opposite end of the word. The bench also drives a software write of E in the same cycle as an exception entry. A design that gave the write priority would leave the wrong E, and every later big-endian access would then mismatch. Reserved and U=0 configurations are driven with E set, so a design that still byte-reversed in those cases would be caught.

// File: rtl/mxe_pkg.sv
// Package: shared types for the mixed-endian load/store data path.
// Assumes a byte-addressed bus whose lane n carries bits 8n+7..8n.
package mxe_pkg;

    // Data endianness mode selected from U, B and E.
    typedef enum logic [1:0] {
        DM_LE   = 2'd0,
        DM_BIBE = 2'd1,
        DM_WIBE = 2'd2
    } dmode_e;

    localparam int REG_W  = 32;
    localparam int WORD_B = REG_W / 8;

    // Bytes moved by an access of the given size code.
    function automatic int size_bytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : WORD_B;
    endfunction

endpackage

// File: rtl/mxe_mode_ctl.sv
// Module: holds the data-endianness bit E and decodes the data mode.
// Assumes exception entry and reset both reload E from exc_endian and win
// over a software write in the same cycle.
module mxe_mode_ctl
    import mxe_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cfg_u,
    input  logic   cfg_b,
    input  logic   exc_endian,
    input  logic   exc_entry,
    input  logic   e_wr_en,
    input  logic   e_wr_val,
    output logic   e_bit,
    output logic   cfg_err,
    output dmode_e dmode
);

    logic e_q;

    // E register: reset and exception entry reload, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= exc_endian;
        end else if (exc_entry) begin
            e_q <= exc_endian;
        end else if (e_wr_en) begin
            e_q <= e_wr_val;
        end
    end

    // Mode decode from U, B, E; bad settings fall back to little-endian.
    always_comb begin
        cfg_err = !cfg_u || (cfg_b && e_q);
        if (cfg_err) begin
            dmode = DM_LE;
        end else if (cfg_b) begin
            dmode = DM_WIBE;
        end else if (e_q) begin
            dmode = DM_BIBE;
        end else begin
            dmode = DM_LE;
        end
    end

    assign e_bit = e_q;

endmodule

// File: rtl/mxe_lane_steer.sv
// Module: combinational byte-lane steering for data loads and stores.
// Assumes the bus is DATA_W bits wide (at least one register word) and that
// a word-crossing access is reported rather than performed.
module mxe_lane_steer
    import mxe_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LW    = $clog2(LANES)
)(
    input  dmode_e              dmode,
    input  logic [LW-1:0]       acc_lsb,
    input  logic [1:0]          acc_size,
    input  logic                acc_sign,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic [REG_W-1:0]    st_data,
    output logic [REG_W-1:0]    ld_data,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [LANES-1:0]    mem_be,
    output logic                split_req
);

    int nb;
    int off;
    int lane;

    // Access geometry: byte count, first lane and word-crossing detection.
    always_comb begin
        nb        = size_bytes(acc_size);
        off       = int'(acc_lsb);
        split_req = ((off + nb) > LANES) ||
                    ((dmode == DM_WIBE) && ((off % nb) != 0));
        lane      = (dmode == DM_WIBE) ? (off ^ (LANES - nb)) : off;
    end

    // Load path: gather lanes, reverse for byte-invariant BE, then extend.
    always_comb begin
        logic [REG_W-1:0] val;
        val = '0;
        if (!split_req) begin
            for (int k = 0; k < WORD_B; k++) begin
                if (k < nb) begin
                    if (dmode == DM_BIBE) begin
                        val[8*k +: 8] = mem_rdata[8*(lane + nb - 1 - k) +: 8];
                    end else begin
                        val[8*k +: 8] = mem_rdata[8*(lane + k) +: 8];
                    end
                end
            end
            for (int i = 0; i < REG_W; i++) begin
                if (acc_sign && (nb < WORD_B) && (i >= 8*nb)) begin
                    val[i] = val[8*nb - 1];
                end
            end
        end
        ld_data = val;
    end

    // Store path: scatter register bytes into lanes and mark byte enables.
    always_comb begin
        mem_wdata = '0;
        mem_be    = '0;
        if (!split_req) begin
            for (int k = 0; k < WORD_B; k++) begin
                if (k < nb) begin
                    mem_be[lane + k] = 1'b1;
                    if (dmode == DM_BIBE) begin
                        mem_wdata[8*(lane + k) +: 8] = st_data[8*(nb - 1 - k) +: 8];
                    end else begin
                        mem_wdata[8*(lane + k) +: 8] = st_data[8*k +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mxe_fetch_align.sv
// Module: extracts 16- or 32-bit instructions from the fetch bus.
// Assumes instructions are little-endian in every mode but legacy BE, where
// only the halfword position within the word flips; E is not consulted.
module mxe_fetch_align
    import mxe_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LW    = $clog2(LANES)
)(
    input  logic                legacy,
    input  logic [LW-1:0]       if_lsb,
    input  logic                if_half,
    input  logic [DATA_W-1:0]   if_rdata,
    output logic [REG_W-1:0]    if_insn,
    output logic                if_fault
);

    // Alignment check, slot selection and zero extension of the instruction.
    always_comb begin
        int slot;
        int nb;
        nb       = if_half ? 2 : WORD_B;
        if_fault = (int'(if_lsb) % nb) != 0;
        slot     = legacy ? (int'(if_lsb) ^ (LANES - nb)) : int'(if_lsb);
        if_insn  = '0;
        if (!if_fault) begin
            if (if_half) begin
                if_insn[15:0] = if_rdata[8*slot +: 16];
            end else begin
                if_insn = if_rdata[8*slot +: REG_W];
            end
        end
    end

endmodule

// File: rtl/mxe_ldst_path.sv
// Module: top of the mixed-endian load/store data path.
// Assumes one access and one fetch are presented per cycle and that the
// caller re-issues split accesses itself.
module mxe_ldst_path
    import mxe_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LW    = $clog2(LANES)
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_u,
    input  logic                cfg_b,
    input  logic                exc_endian,
    input  logic                exc_entry,
    input  logic                e_wr_en,
    input  logic                e_wr_val,
    output logic                e_bit,
    output logic                cfg_err,
    input  logic [LW-1:0]       acc_lsb,
    input  logic [1:0]          acc_size,
    input  logic                acc_sign,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic [REG_W-1:0]    st_data,
    output logic [REG_W-1:0]    ld_data,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [LANES-1:0]    mem_be,
    output logic                split_req,
    input  logic [LW-1:0]       if_lsb,
    input  logic                if_half,
    input  logic [DATA_W-1:0]   if_rdata,
    output logic [REG_W-1:0]    if_insn,
    output logic                if_fault
);

    dmode_e dmode;

    mxe_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_u      (cfg_u),
        .cfg_b      (cfg_b),
        .exc_endian (exc_endian),
        .exc_entry  (exc_entry),
        .e_wr_en    (e_wr_en),
        .e_wr_val   (e_wr_val),
        .e_bit      (e_bit),
        .cfg_err    (cfg_err),
        .dmode      (dmode)
    );

    mxe_lane_steer #(.DATA_W(DATA_W)) u_steer (
        .dmode      (dmode),
        .acc_lsb    (acc_lsb),
        .acc_size   (acc_size),
        .acc_sign   (acc_sign),
        .mem_rdata  (mem_rdata),
        .st_data    (st_data),
        .ld_data    (ld_data),
        .mem_wdata  (mem_wdata),
        .mem_be     (mem_be),
        .split_req  (split_req)
    );

    mxe_fetch_align #(.DATA_W(DATA_W)) u_fetch (
        .legacy     (dmode == DM_WIBE),
        .if_lsb     (if_lsb),
        .if_half    (if_half),
        .if_rdata   (if_rdata),
        .if_insn    (if_insn),
        .if_fault   (if_fault)
    );

endmodule

// File: rtl/mxe_ldst_checker.sv
// Module: property checker for mxe_ldst_path, bound into every instance.
module mxe_ldst_checker
    import mxe_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LW    = $clog2(LANES)
)(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_u,
    input logic                cfg_b,
    input logic                exc_endian,
    input logic                exc_entry,
    input logic                e_wr_en,
    input logic                e_wr_val,
    input logic                e_bit,
    input logic                cfg_err,
    input logic [1:0]          acc_size,
    input logic [REG_W-1:0]    ld_data,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic [LANES-1:0]    mem_be,
    input logic                split_req,
    input logic [LW-1:0]       if_lsb,
    input logic                if_half,
    input logic [REG_W-1:0]    if_insn,
    input logic                if_fault
);

    AST_E_EXC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (e_bit == $past(exc_endian)));                      // R2
    AST_E_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (e_wr_en && !exc_entry) |=> (e_bit == $past(e_wr_val)));          // R2
    AST_E_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_wr_en && !exc_entry) |=> $stable(e_bit));                     // R2
    AST_CFG_NO_U: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_u |-> cfg_err);                                              // R1
    AST_CFG_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_u && cfg_b && e_bit) |-> cfg_err);                           // R1
    AST_SPLIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        split_req |-> (mem_be == '0 && ld_data == '0 && mem_wdata == '0)); // R8
    AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !split_req |-> ($countones(mem_be) == size_bytes(acc_size)));     // R8
    AST_FETCH_HALF_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (if_half && if_lsb[0]) |-> if_fault);                             // R10
    AST_FETCH_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        if_fault |-> (if_insn == '0));                                    // R10
    AST_FETCH_HALF_ZX: assert property (@(posedge clk) disable iff (!rst_n)
        if_half |-> (if_insn[REG_W-1:16] == '0));                         // R9

endmodule

bind mxe_ldst_path mxe_ldst_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mxe_ldst_path_bench.sv
`timescale 1ns/1ps
module mxe_ldst_path_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_u, cfg_b, exc_endian, exc_entry, e_wr_en, e_wr_val;
    logic        e_bit, cfg_err;
    logic [1:0]  acc_lsb, acc_size;
    logic        acc_sign;
    logic [31:0] mem_rdata, st_data, ld_data, mem_wdata;
    logic [3:0]  mem_be;
    logic        split_req;
    logic [1:0]  if_lsb;
    logic        if_half;
    logic [31:0] if_rdata, if_insn;
    logic        if_fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic m_e;

    always #4 clk = ~clk;

    mxe_ldst_path u_mxe_ldst_path (.*);

    // Behavioural model of the E bit.
    always @(posedge clk) begin
        if (!rst_n || exc_entry) m_e <= exc_endian;
        else if (e_wr_en)        m_e <= e_wr_val;
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare every output against the byte-level model.
    task automatic compare();
        int md, n, off, lane, src;
        bit err, spl;
        logic [31:0] x_ld, x_wd, x_ins;
        logic [3:0]  x_be;
        bit x_flt;
        string tag;
        err = !cfg_u || (cfg_b && m_e);
        md  = err ? 0 : (cfg_b ? 2 : (m_e ? 1 : 0));
        n   = (acc_size == 0) ? 1 : (acc_size == 1) ? 2 : 4;
        off = acc_lsb;
        spl = (off + n > 4) || (md == 2 && (off % n) != 0);
        x_ld = 0; x_wd = 0; x_be = 0;
        if (!spl) begin
            lane = (md == 2) ? (off ^ (4 - n)) : off;
            for (int k = 0; k < n; k++) begin
                src = (md == 1) ? lane + n - 1 - k : lane + k;
                x_ld[8*k +: 8] = mem_rdata[8*src +: 8];
                x_wd[8*src +: 8] = st_data[8*k +: 8];
                x_be[src] = 1'b1;
            end
            if (acc_sign && n < 4 && x_ld[8*n-1])
                for (int i = 8*n; i < 32; i++) x_ld[i] = 1'b1;
        end
        if (err)                   tag = "R1";
        else if (spl)              tag = "R8";
        else if (md == 2)          tag = "R6";
        else if (acc_sign && n<4)  tag = "R7";
        else if (md == 1 && n==2)  tag = "R4";
        else if (md == 1 && n==4)  tag = "R5";
        else                       tag = "R3";
        chk(tag, "ld_data", ld_data, x_ld);
        chk(tag, "mem_wdata", mem_wdata, x_wd);
        chk("R8", "mem_be", {28'd0, mem_be}, {28'd0, x_be});
        chk("R8", "split_req", {31'd0, split_req}, {31'd0, spl});
        chk("R1", "cfg_err", {31'd0, cfg_err}, {31'd0, err});
        chk("R2", "e_bit", {31'd0, e_bit}, {31'd0, m_e});
        x_flt = if_half ? if_lsb[0] : (if_lsb != 0);
        x_ins = 0;
        if (!x_flt) begin
            if (!if_half) x_ins = if_rdata;
            else x_ins[15:0] = if_rdata[16*((md == 2) ? !if_lsb[1] : if_lsb[1]) +: 16];
        end
        chk(x_flt ? "R10" : "R9", "if_insn", if_insn, x_ins);
        chk("R10", "if_fault", {31'd0, if_fault}, {31'd0, x_flt});
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        @(posedge clk);
        #1;
        mem_rdata = $urandom;
        st_data   = $urandom;
        if_rdata  = $urandom;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_u = 1; cfg_b = 0; exc_endian = 1; exc_entry = 0;
        e_wr_en = 0; e_wr_val = 0; acc_lsb = 0; acc_size = 0; acc_sign = 0;
        mem_rdata = 32'h8899_AABB; st_data = 32'h1122_3344;
        if_lsb = 0; if_half = 0; if_rdata = 32'hCAFE_F00D;
        @(posedge clk); #1;
        step();                           // R2: reset loads exc_endian
        rst_n = 1; exc_endian = 0;
        step();
        // R2: software write and exception entry in the same cycle
        e_wr_en = 1; e_wr_val = 1; exc_entry = 1;
        step();
        exc_entry = 0; e_wr_val = 1;
        step();
        e_wr_en = 0;
        step();
        exc_endian = 0; exc_entry = 1;
        step();
        exc_entry = 0;
        // Sweep every configuration class, size, offset and sign.
        for (int c = 0; c < 6; c++) begin
            cfg_u = (c < 4); cfg_b = (c == 2 || c == 3);
            e_wr_en = 1; e_wr_val = (c == 1 || c == 3 || c == 5);
            step();
            e_wr_en = 0;
            for (int sz = 0; sz < 4; sz++)
                for (int o = 0; o < 4; o++)
                    for (int sg = 0; sg < 2; sg++) begin
                        acc_size = sz[1:0]; acc_lsb = o[1:0]; acc_sign = sg[0];
                        if_lsb = o[1:0]; if_half = sg[0] ^ sz[0];
                        mem_rdata = (sg != 0) ? 32'hF18E_7C80 : $urandom;
                        step();
                    end
        end
        step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule